// File: doc/BRIEF.md
# Chunk De-interleaver

The block pulls one image out of a byte stream in which several images have been merged by taking turns in fixed-size chunks. The first chunk of the stream belongs to image 1, the next to image 2, and so on. After the last image the rotation starts again at image 1. Every byte that enters is counted. A byte whose chunk belongs to the selected image goes to the output port. Every other byte is taken in and thrown away.

A single-cycle restart pulse at the start of each pass clears the position to the first byte of the first chunk. The selector is 1-based. A selector of zero, or one above the image count, makes the block consume and discard every byte. Both sides of the block use valid/ready handshakes. Discarded bytes are consumed at one per cycle whatever the output side is doing.

Top module: `chunk_deint`

## Requirements
- R1: After reset `out_valid` is low and the position is byte 0 of a chunk owned by image 1.
- R2: The byte at zero-based global index i belongs to image ((i / CHUNK_BYTES) mod NUM_IMAGES) + 1. Bytes of the selected image appear on `out_data` in their input order, with no loss and no duplicates.
- R3: While `restart` is low, a byte of a non-selected image is accepted (`in_ready` high) whatever the state of `out_ready`, and it never reaches the output.
- R4: Each accepted byte advances the position by one, whether it is forwarded or dropped. Bytes offered while `in_ready` is low do not advance it.
- R5: `restart` returns the position to global index 0, and `in_ready` is low during the restart cycle.
- R6: When `sel` is 0 or greater than NUM_IMAGES, every byte is accepted and dropped, and `out_valid` stays low.
- R7: A forwarded byte is presented with `out_valid` high one cycle after it is accepted. `out_valid` and `out_data` then hold steady until `out_ready` is high.
- R8: A byte of the selected image is refused (`in_ready` low) while the output holds a byte and `out_ready` is low. Otherwise it is accepted.
- R9: After the last image's chunk the rotation wraps back to image 1, and this repeats without limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Pulse at stream start; clears the byte position |
| sel | input | SEL_W | 1-based number of the image to extract |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted this cycle when high with `in_valid` |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |

## Verification
The bench builds the block with CHUNK_BYTES = 4, NUM_IMAGES = 3 and SEL_W = 4. Streams of a few dozen bytes therefore cross many chunk edges and several complete rotations, so the chunk wrap and the image wrap are both exercised often. With a 4-bit selector, both 0 and 5 can be driven, which covers the two out-of-range cases. The streams run with and without output backpressure. A restart is issued in the middle of a stream to show that the position returns to the first chunk.

// File: rtl/chunk_deint_pkg.sv
package chunk_deint_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  vld;
        byte_t data;
    } outreg_t;

endpackage

// File: rtl/chunk_pos_ctr.sv
module chunk_pos_ctr #(
    parameter int CHUNK_BYTES = 288,
    parameter int NUM_IMAGES  = 2,
    parameter int IDX_W       = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] img_idx
);
    localparam int OFF_W = (CHUNK_BYTES > 1) ? $clog2(CHUNK_BYTES) : 1;
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(CHUNK_BYTES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_IMAGES - 1);

    typedef struct packed {
        logic [OFF_W-1:0] offs;
        logic [IDX_W-1:0] idx;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (clear) begin
            pos_d.offs = '0;
            pos_d.idx  = '0;
        end else if (step) begin
            if (pos_q.offs == OFF_LAST) begin
                pos_d.offs = '0;
                pos_d.idx  = (pos_q.idx == IDX_LAST) ? '0 : pos_q.idx + 1'b1;
            end else begin
                pos_d.offs = pos_q.offs + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign img_idx = pos_q.idx;
endmodule

// File: rtl/chunk_sel_match.sv
module chunk_sel_match #(
    parameter int NUM_IMAGES = 2,
    parameter int SEL_W      = 4,
    parameter int IDX_W      = 1
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [IDX_W-1:0] img_idx,
    output logic             hit
);
    logic sel_ok;

    always_comb begin
        sel_ok = (int'(sel) >= 1) && (int'(sel) <= NUM_IMAGES);
        hit    = sel_ok && (int'(img_idx) == int'(sel) - 1);
    end
endmodule

// File: rtl/chunk_out_stage.sv
module chunk_out_stage
    import chunk_deint_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  byte_t din,
    input  logic  out_ready,
    output logic  stall,
    output logic  out_valid,
    output byte_t out_data
);
    outreg_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (reg_q.vld && out_ready) reg_d.vld = 1'b0;
        if (load) begin
            reg_d.vld  = 1'b1;
            reg_d.data = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign stall     = reg_q.vld && !out_ready;
    assign out_valid = reg_q.vld;
    assign out_data  = reg_q.data;
endmodule

// File: rtl/chunk_deint.sv
module chunk_deint
    import chunk_deint_pkg::*;
#(
    parameter int CHUNK_BYTES = 288,
    parameter int NUM_IMAGES  = 2,
    parameter int SEL_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data
);
    localparam int IDX_W = (NUM_IMAGES > 1) ? $clog2(NUM_IMAGES) : 1;

    logic [IDX_W-1:0] img_idx;
    logic             hit;
    logic             stall;
    logic             take;

    chunk_pos_ctr #(
        .CHUNK_BYTES(CHUNK_BYTES),
        .NUM_IMAGES (NUM_IMAGES),
        .IDX_W      (IDX_W)
    ) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (restart),
        .step   (take),
        .img_idx(img_idx)
    );

    chunk_sel_match #(
        .NUM_IMAGES(NUM_IMAGES),
        .SEL_W     (SEL_W),
        .IDX_W     (IDX_W)
    ) u_match (
        .sel    (sel),
        .img_idx(img_idx),
        .hit    (hit)
    );

    always_comb begin
        in_ready = !restart && (!hit || !stall);
        take     = in_valid && in_ready;
    end

    chunk_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take && hit),
        .din      (in_data),
        .out_ready(out_ready),
        .stall    (stall),
        .out_valid(out_valid),
        .out_data (out_data)
    );
endmodule

// File: rtl/chunk_deint_chk.sv
module chunk_deint_chk #(
    parameter int NUM_IMAGES = 2,
    parameter int SEL_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart,
    input logic [SEL_W-1:0] sel,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

    // R5
    restart_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !in_ready);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R6
    bad_sel_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && ((int'(sel) == 0) || (int'(sel) > NUM_IMAGES))) |-> in_ready);

    // R6
    bad_sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> ((int'($past(sel)) >= 1) && (int'($past(sel)) <= NUM_IMAGES)));
endmodule

bind chunk_deint chunk_deint_chk #(
    .NUM_IMAGES(NUM_IMAGES),
    .SEL_W     (SEL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .sel      (sel),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
);

// File: tb/tb_chunk_deint.sv
module tb_chunk_deint;
    localparam int CHUNK = 4;
    localparam int NIMG  = 3;
    localparam int SELW  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            restart = 1'b0;
    logic [SELW-1:0] sel = '0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [7:0]      in_data = '0;
    logic            out_valid;
    logic            out_ready = 1'b1;
    logic [7:0]      out_data;

    int   checks = 0;
    int   failures = 0;
    int   g = 0;
    int   cyc = 0;
    bit   bp = 1'b0;
    bit   done = 1'b0;
    bit   held_prev = 1'b0;
    logic [7:0] held_data = '0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    chunk_deint #(
        .CHUNK_BYTES(CHUNK),
        .NUM_IMAGES (NIMG),
        .SEL_W      (SELW)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .sel      (sel),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_data (out_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: offers n bytes under selector s and records the expected output.
    task automatic send(input int s, input int n);
        @(negedge clk);
        sel = SELW'(s);
        for (int k = 0; k < n; k++) begin
            logic [7:0] v;
            bit         match;
            bit         accepted;
            v     = 8'((g * 13 + 5 + s) & 255);
            match = (s >= 1) && (s <= NIMG) && (((g / CHUNK) % NIMG) == s - 1);
            if (k != 0) @(negedge clk);
            in_valid = 1'b1;
            in_data  = v;
            accepted = 1'b0;
            while (!accepted) begin
                bit exp_r;
                #1;
                exp_r = match ? !(out_valid && !out_ready) : 1'b1;
                if (match) chk(in_ready == exp_r, "R8", "in_ready for selected byte", in_ready, exp_r);
                else       chk(in_ready == exp_r, "R3", "in_ready for dropped byte", in_ready, exp_r);
                accepted = in_ready;
                @(posedge clk);
                if (!accepted) @(negedge clk);
            end
            if (match) exp_q.push_back(v);
            g++;   // R4: every accepted byte advances the position
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart = 1'b1;
        #1;
        chk(in_ready == 1'b0, "R5", "in_ready during restart", in_ready, 0);
        @(negedge clk);
        restart = 1'b0;
        g = 0;
    endtask

    task automatic drain();
        bp = 1'b0;
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "bytes still expected", exp_q.size(), 0);
    endtask

    // Monitor / scoreboard
    always begin
        @(negedge clk);
        cyc++;
        out_ready = bp ? ((cyc % 3) == 0) : 1'b1;
        #2;
        if (rst_n) begin
            if (held_prev) begin
                chk(out_valid == 1'b1, "R7", "valid held under backpressure", out_valid, 1);
                chk(out_data == held_data, "R7", "data held under backpressure", out_data, held_data);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected output byte", out_data, -1);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(out_data == e, "R2", "forwarded byte", out_data, e);
                end
            end
            held_prev = out_valid && !out_ready;
            held_data = out_data;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

        // R1: no restart, first chunk must belong to image 1
        send(1, 30);
        drain();

        // R9: image 3 across several rotations, with backpressure (R7, R8)
        do_restart();
        bp = 1'b1;
        send(3, 40);
        drain();

        // R5: restart mid-stream then begin again from index 0
        do_restart();
        bp = 1'b1;
        send(2, 6);
        do_restart();
        send(2, 25);
        drain();

        // R6: out-of-range selectors drop everything
        do_restart();
        send(0, 20);
        send(5, 20);
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R6", "out_valid with bad selector", out_valid, 0);
        drain();

        // R4: position kept across selector change without restart
        send(1, 14);
        send(2, 14);
        drain();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule